// File: doc/BRIEF.md
# Accumulator-Temp Register Execution Unit

This block executes one-byte instructions that need no operand fetch, on behalf of an 8-bit-bus controller core. It owns a 16-bit accumulator, a 16-bit temporary register, three 16-bit pointer registers (extra pointer, index, stack) and the N, Z, V and C condition flags. The fetch stage presents each opcode with a one-cycle strobe, together with the current program counter value.

The block supports these operations:
- byte and word exchanges between the accumulator and the other registers;
- loading the accumulator from the program counter;
- byte and word add-with-carry;
- byte and word subtract-with-borrow in which the temporary register is the minuend.

Each finished instruction produces a one-cycle `done` pulse. An unsupported opcode produces an `illegal` pulse instead and changes nothing.

Top module: `atr_exec_unit`

## Requirements
- R1: While `rstN` is low, all five registers and the flags are zero, and `busy`, `done` and `illegal` are low.
- R2: Opcode 0x42 exchanges the low bytes of the accumulator and the temporary register. The high bytes and the flags keep their values.
- R3: Opcode 0x43 exchanges the whole accumulator and temporary register. The flags keep their values.
- R4: Opcodes 0xF7, 0xF6 and 0xF5 exchange the accumulator with the extra pointer, index and stack registers respectively. The flags keep their values.
- R5: Opcode 0xF0 loads the accumulator with the `pcIn` value sampled in the acceptance cycle. It takes two cycles: `busy` is high in the cycle after acceptance, and the accumulator changes on the following edge.
- R6: Opcode 0x22 sets the low byte of the accumulator to low(A) + low(T) + C. The high byte is kept.
- R7: Opcode 0x23 sets the accumulator to A + T + C, computed over 16 bits.
- R8: Opcode 0x32 sets the low byte of the accumulator to low(T) − low(A) − C. The high byte is kept.
- R9: Opcode 0x33 sets the accumulator to T − A − C, computed over 16 bits.
- R10: After an arithmetic opcode, `flagsOut` = {N,Z,V,C}, with N in bit 3 and C in bit 0, all at the width of the operation. N is the result's top bit. Z is set when the result is zero. V is signed overflow. C is the carry out of an add, or the borrow of a subtract.
- R11: `done` is high for exactly one cycle, directly after the edge on which a supported instruction finishes.
- R12: An opcode outside the supported set raises `illegal` for one cycle after acceptance, raises no `done`, and leaves every register and flag unchanged.
- R13: A strobe that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Opcode strobe |
| opCode | input | 8 | Opcode byte |
| pcIn | input | 16 | Current program counter |
| busy | output | 1 | Two-cycle instruction in progress |
| done | output | 1 | Instruction finished pulse |
| illegal | output | 1 | Unsupported opcode pulse |
| accOut | output | 16 | Accumulator |
| tmpOut | output | 16 | Temporary register |
| extOut | output | 16 | Extra pointer register |
| idxOut | output | 16 | Index register |
| stkOut | output | 16 | Stack register |
| flagsOut | output | 4 | {N,Z,V,C} |

## Verification
The bench builds the block with its default data width of 16, which gives an 8-bit byte half. Only at these widths do the opcode semantics match the instruction set. With them, both the byte-wide and word-wide carry, borrow and overflow boundaries can be reached, and register contents can be seeded through the program-counter load and the exchange opcodes. Carry-in takes both values during the random run, and explicit sequences also force each value.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int OP_W = 8;

  typedef enum logic [3:0] {
    OP_NONE, OP_SWAP_LO, OP_SWAP_AT, OP_SWAP_EP, OP_SWAP_IX, OP_SWAP_SP,
    OP_LOAD_PC, OP_ADD_B, OP_ADD_W, OP_SUB_B, OP_SUB_W
  } opKind_e;

  typedef struct packed {
    logic    exec;
    opKind_e kind;
    logic    latchPc;
  } ctrlStrobe_t;

  function automatic opKind_e decodeOp(input logic [OP_W-1:0] code);
    case (code)
      8'h42:   return OP_SWAP_LO;
      8'h43:   return OP_SWAP_AT;
      8'hF7:   return OP_SWAP_EP;
      8'hF6:   return OP_SWAP_IX;
      8'hF5:   return OP_SWAP_SP;
      8'hF0:   return OP_LOAD_PC;
      8'h22:   return OP_ADD_B;
      8'h23:   return OP_ADD_W;
      8'h32:   return OP_SUB_B;
      8'h33:   return OP_SUB_W;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/atr_alu.sv
module atr_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opT,
  input  logic         cin,
  input  logic         isSub,
  output logic [W-1:0] res,
  output logic [3:0]   flags
);
  logic [W:0] full;
  logic       ovf;

  always_comb begin
    if (isSub) begin
      full = {1'b0, opT} - {1'b0, opA} - {{W{1'b0}}, cin};
      ovf  = (opT[W-1] ^ opA[W-1]) & (opT[W-1] ^ full[W-1]);
    end else begin
      full = {1'b0, opA} + {1'b0, opT} + {{W{1'b0}}, cin};
      ovf  = ~(opA[W-1] ^ opT[W-1]) & (opA[W-1] ^ full[W-1]);
    end
    res   = full[W-1:0];
    flags = {full[W-1], (full[W-1:0] == '0), ovf, full[W]};
  end
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobe_t     strobe,
  output logic            busy,
  output logic            done,
  output logic            illegal
);
  logic    pendPc;
  logic    accept;
  opKind_e kindDec;

  assign accept  = opValid && !pendPc;
  assign kindDec = decodeOp(opCode);
  assign busy    = pendPc;

  always_comb begin
    strobe         = '0;
    strobe.kind    = OP_NONE;
    if (pendPc) begin
      strobe.exec = 1'b1;
      strobe.kind = OP_LOAD_PC;
    end else if (accept && kindDec != OP_NONE && kindDec != OP_LOAD_PC) begin
      strobe.exec = 1'b1;
      strobe.kind = kindDec;
    end
    strobe.latchPc = accept && (kindDec == OP_LOAD_PC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPc  <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      pendPc  <= strobe.latchPc;
      done    <= strobe.exec;
      illegal <= accept && (kindDec == OP_NONE);
    end
  end

  AST_PC_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchPc |=> busy && !done); // R5
  AST_PC_FINISHES: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done && !busy); // R11
  AST_DONE_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && illegal)); // R12
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !illegal); // R13
endmodule

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] tmpOut,
  output logic [DATA_W-1:0] extOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [DATA_W-1:0] stkOut,
  output logic [3:0]        flagsOut
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] accR, tmpR, epR, ixR, spR, pcHold;
  logic [3:0]        flagR;
  logic [HALF_W-1:0] byteRes;
  logic [DATA_W-1:0] wordRes;
  logic [3:0]        byteFlags, wordFlags;
  logic              isSub, isByteOp, isSwap, isWordArith;

  assign isSub       = (strobe.kind == OP_SUB_B) || (strobe.kind == OP_SUB_W);
  assign isByteOp    = strobe.exec && (strobe.kind == OP_SWAP_LO ||
                       strobe.kind == OP_ADD_B || strobe.kind == OP_SUB_B);
  assign isSwap      = strobe.exec && (strobe.kind == OP_SWAP_LO || strobe.kind == OP_SWAP_AT ||
                       strobe.kind == OP_SWAP_EP || strobe.kind == OP_SWAP_IX ||
                       strobe.kind == OP_SWAP_SP);
  assign isWordArith = strobe.exec && (strobe.kind == OP_ADD_W || strobe.kind == OP_SUB_W);

  atr_alu #(.W(HALF_W)) byteAlu_i (
    .opA(accR[HALF_W-1:0]), .opT(tmpR[HALF_W-1:0]), .cin(flagR[0]),
    .isSub(isSub), .res(byteRes), .flags(byteFlags)
  );

  atr_alu #(.W(DATA_W)) wordAlu_i (
    .opA(accR), .opT(tmpR), .cin(flagR[0]),
    .isSub(isSub), .res(wordRes), .flags(wordFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR   <= '0;
      tmpR   <= '0;
      epR    <= '0;
      ixR    <= '0;
      spR    <= '0;
      pcHold <= '0;
      flagR  <= '0;
    end else begin
      if (strobe.latchPc) pcHold <= pcIn;
      if (strobe.exec) begin
        case (strobe.kind)
          OP_SWAP_LO: begin
            accR[HALF_W-1:0] <= tmpR[HALF_W-1:0];
            tmpR[HALF_W-1:0] <= accR[HALF_W-1:0];
          end
          OP_SWAP_AT: begin accR <= tmpR; tmpR <= accR; end
          OP_SWAP_EP: begin accR <= epR;  epR  <= accR; end
          OP_SWAP_IX: begin accR <= ixR;  ixR  <= accR; end
          OP_SWAP_SP: begin accR <= spR;  spR  <= accR; end
          OP_LOAD_PC: accR <= pcHold;
          OP_ADD_B, OP_SUB_B: begin
            accR[HALF_W-1:0] <= byteRes;
            flagR            <= byteFlags;
          end
          OP_ADD_W, OP_SUB_W: begin
            accR  <= wordRes;
            flagR <= wordFlags;
          end
          default: ;
        endcase
      end
    end
  end

  assign accOut   = accR;
  assign tmpOut   = tmpR;
  assign extOut   = epR;
  assign idxOut   = ixR;
  assign stkOut   = spR;
  assign flagsOut = flagR;

  AST_BYTE_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    isByteOp |=> accR[DATA_W-1:HALF_W] == $past(accR[DATA_W-1:HALF_W])); // R2
  AST_SWAP_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    isSwap |=> $stable(flagR)); // R4
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.kind == OP_SWAP_AT) |=> accR == $past(tmpR) && tmpR == $past(accR)); // R3
  AST_WORD_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    isWordArith |=> flagR[2] == (accR == '0)); // R10
  AST_WORD_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    isWordArith |=> flagR[3] == accR[DATA_W-1]); // R10
endmodule

// File: rtl/atr_exec_unit.sv
module atr_exec_unit
  import atr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] pcIn,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] tmpOut,
  output logic [DATA_W-1:0] extOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [DATA_W-1:0] stkOut,
  output logic [3:0]        flagsOut
);
  ctrlStrobe_t strobe;

  atr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .strobe(strobe), .busy(busy), .done(done), .illegal(illegal)
  );

  atr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn),
    .accOut(accOut), .tmpOut(tmpOut), .extOut(extOut),
    .idxOut(idxOut), .stkOut(stkOut), .flagsOut(flagsOut)
  );

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(accOut) && $stable(tmpOut) && $stable(flagsOut)); // R12
endmodule

// File: tb/atr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module atr_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = 8'h00;
  logic [15:0] pcIn = 16'h0000;
  logic        busy, done, illegal;
  logic [15:0] accOut, tmpOut, extOut, idxOut, stkOut;
  logic [3:0]  flagsOut;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  atr_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .pcIn(pcIn),
    .busy(busy), .done(done), .illegal(illegal), .accOut(accOut), .tmpOut(tmpOut),
    .extOut(extOut), .idxOut(idxOut), .stkOut(stkOut), .flagsOut(flagsOut)
  );

  // Behavioural reference state
  logic [15:0] mA, mT, mE, mI, mS, mPc;
  logic        mN, mZ, mV, mC, mPend, mDone, mIll;

  task automatic setFlags(input int res, input int width, input bit ovf, input bit cy);
    mN = res[width-1];
    mZ = (res == 0);
    mV = ovf;
    mC = cy;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA = 0; mT = 0; mE = 0; mI = 0; mS = 0; mPc = 0;
      mN = 0; mZ = 0; mV = 0; mC = 0; mPend = 0; mDone = 0; mIll = 0;
    end else begin
      mDone = 0; mIll = 0;
      if (mPend) begin
        mA = mPc; mPend = 0; mDone = 1;            // R5, R13: strobe ignored
      end else if (opValid) begin
        int s, a, t, r;
        logic [15:0] tmp;
        mDone = 1;
        case (opCode)
          8'h42: begin tmp = mA; mA[7:0] = mT[7:0]; mT[7:0] = tmp[7:0]; end
          8'h43: begin tmp = mA; mA = mT; mT = tmp; end
          8'hF7: begin tmp = mA; mA = mE; mE = tmp; end
          8'hF6: begin tmp = mA; mA = mI; mI = tmp; end
          8'hF5: begin tmp = mA; mA = mS; mS = tmp; end
          8'hF0: begin mPc = pcIn; mPend = 1; mDone = 0; end
          8'h22: begin
            a = int'(mA[7:0]); t = int'(mT[7:0]);
            s = a + t + int'(mC); r = s % 256;
            setFlags(r, 8, ((a ^ r) & (t ^ r) & 128) != 0, s > 255);
            mA[7:0] = r[7:0];
          end
          8'h23: begin
            a = int'(mA); t = int'(mT);
            s = a + t + int'(mC); r = s % 65536;
            setFlags(r, 16, ((a ^ r) & (t ^ r) & 32768) != 0, s > 65535);
            mA = r[15:0];
          end
          8'h32: begin
            a = int'(mA[7:0]); t = int'(mT[7:0]);
            s = t - a - int'(mC); r = (s + 256) % 256;
            setFlags(r, 8, ((t ^ a) & (t ^ r) & 128) != 0, s < 0);
            mA[7:0] = r[7:0];
          end
          8'h33: begin
            a = int'(mA); t = int'(mT);
            s = t - a - int'(mC); r = (s + 65536) % 65536;
            setFlags(r, 16, ((t ^ a) & (t ^ r) & 32768) != 0, s < 0);
            mA = r[15:0];
          end
          default: begin mDone = 0; mIll = 1; end   // R12
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "accOut", accOut, mA);
      chk(curReq, "tmpOut", tmpOut, mT);
      chk(curReq, "extOut", extOut, mE);
      chk(curReq, "idxOut", idxOut, mI);
      chk(curReq, "stkOut", stkOut, mS);
      chk("R10", "flagsOut", flagsOut, {mN, mZ, mV, mC});
      chk("R5", "busy", busy, mPend);
      chk("R11", "done", done, mDone);
      chk("R12", "illegal", illegal, mIll);
    end
  end

  function automatic string reqOf(input logic [7:0] op);
    case (op)
      8'h42: return "R2";
      8'h43: return "R3";
      8'hF7, 8'hF6, 8'hF5: return "R4";
      8'hF0: return "R5";
      8'h22: return "R6";
      8'h23: return "R7";
      8'h32: return "R8";
      8'h33: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic issue(input logic [7:0] op, input logic [15:0] pc);
    curReq = reqOf(op);
    opValid = 1; opCode = op; pcIn = pc;
    @(negedge clk);
    opValid = 0;
    if (op == 8'hF0) begin
      opValid = 1; opCode = 8'h43; pcIn = ~pc;    // R13: must be ignored
      @(negedge clk);
      opValid = 0;
      curReq = "R13";
    end
  endtask

  task automatic setAT(input logic [15:0] aVal, input logic [15:0] tVal);
    issue(8'hF0, tVal);
    issue(8'h43, 0);
    issue(8'hF0, aVal);
  endtask

  localparam logic [7:0] LEGAL [10] = '{8'h42, 8'h43, 8'hF7, 8'hF6, 8'hF5,
                                        8'hF0, 8'h22, 8'h23, 8'h32, 8'h33};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc", accOut, 0);   chk("R1", "tmp", tmpOut, 0);
    chk("R1", "ext", extOut, 0);   chk("R1", "idx", idxOut, 0);
    chk("R1", "stk", stkOut, 0);   chk("R1", "flags", flagsOut, 0);
    chk("R1", "busy", busy, 0);    chk("R1", "done", done, 0);
    chk("R1", "illegal", illegal, 0);
    rstN = 1;
    @(negedge clk);
    // R4 pointer swaps seeded through R5 load
    issue(8'hF0, 16'h1111); issue(8'hF7, 0);
    issue(8'hF0, 16'h2222); issue(8'hF6, 0);
    issue(8'hF0, 16'h3333); issue(8'hF5, 0);
    // R6 byte overflow 0x7F+0x01, then carry-in 1 via 0xFF+0x01
    setAT(16'hAB7F, 16'h5501); issue(8'h22, 0);
    setAT(16'h00FF, 16'h0001); issue(8'h22, 0); issue(8'h22, 0);
    // R7 word carry to zero, then with carry in
    setAT(16'hFFFF, 16'h0001); issue(8'h23, 0); issue(8'h23, 0);
    // R8 and R9 borrow cases, T as minuend
    setAT(16'h1205, 16'h3403); issue(8'h32, 0); issue(8'h32, 0);
    setAT(16'h0001, 16'h8000); issue(8'h33, 0); issue(8'h33, 0);
    // R2 low-byte swap, R12 illegal opcodes
    setAT(16'hA1B2, 16'hC3D4); issue(8'h42, 0);
    issue(8'h00, 0); issue(8'hFF, 0); issue(8'h44, 0);
    // Random mix of all opcodes
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      op = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(0, 255)) : LEGAL[$urandom_range(0, 9)];
      issue(op, 16'($urandom));
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule